// File: doc/BRIEF.md
# DMA Channel Address/Count Engine

This block holds the address and transfer-count state for a group of four DMA channels and advances the state of the channel being served each time a transfer finishes. Each channel keeps a base and a current address and a base and a current word count, all 16 bits. A load port writes the base and current registers of one channel at once and arms that channel by clearing its mask bit. On each transfer-done strobe the current address of the active channel moves up or down and its count drops. The step is two for a channel set to 16-bit width while the wide mode is on, and one otherwise.

A block ends when the count underflows or when an external end-of-process request is honoured. The request is taken only while the controller is in an active state and takes effect at the next S2 state. At the end of a block the channel either reloads its current registers from its base registers or masks itself. The engine also produces a width/latch-enable output, and its output-enable follows the wide mode. In a memory-to-memory move, channels 0 and 1 act as a pair whose width is 16 bits if either of them is set wide.

Top module: `dma_addr_cnt_engine`

## Requirements
- R1: After reset every base and current register is zero, all four mask bits are set, and `tc_o` and `eop_o` are low.
- R2: A load pulse on `ld_i` writes `ld_addr_i`/`ld_cnt_i` into both the base and the current registers of channel `ld_ch_i` and clears that channel's mask bit, visible after the next clock edge.
- R3: On `xfer_done_i`, an 8-bit step changes the active channel's current address by +1 (`dir_dn_i` bit 0) or -1 (`dir_dn_i` bit 1) and decrements its current count by 1.
- R4: When `wide_mode_i` is 1 and the channel's `width16_i` bit is 1, the address moves by 2 and the count drops by 2. When `wide_mode_i` is 0, the width bit has no effect and the step is 1.
- R5: Address and count arithmetic wraps modulo 2^16 with no carry out, for both step sizes.
- R6: A transfer whose count is below its step size (the count underflows) raises `tc_o` and `eop_o` for exactly the one cycle after that edge.
- R7: With its autoinitialize bit clear, a channel that reaches end of process sets its mask bit and keeps the stepped current values.
- R8: With its autoinitialize bit set, end of process reloads the current address and count from the base registers and leaves the mask bit clear.
- R9: `ext_eop_i` is ignored while `phase_i` is 0 (idle; 1 = S1, 2 = S2, 3 = other active state). A request seen in an active state is held and, at the next S2 edge, ends the active channel's block, with `eop_o` high in the following cycle and `tc_o` low.
- R10: A held external request is dropped if `phase_i` returns to idle before an S2 state.
- R11: With `m2m_i` set and the active channel 0 or 1, both channels of the pair step by the 16-bit rule if either `width16_i[0]` or `width16_i[1]` is 1 (wide mode on).
- R12: `dwle_oe_o` equals `wide_mode_i`. With it high, `dwle_o` in S1 is 0 for a 16-bit active channel and 1 for an 8-bit one. Outside S1 it is 1 during a 16-bit memory-to-memory move and 0 otherwise. With wide mode off it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_i | input | 1 | Load strobe for one channel's registers |
| ld_ch_i | input | 2 | Channel written by the load |
| ld_addr_i | input | 16 | Start address to load |
| ld_cnt_i | input | 16 | Word count to load |
| xfer_done_i | input | 1 | One transfer of the active channel completed |
| act_ch_i | input | 2 | Channel currently served |
| dir_dn_i | input | 4 | Per channel: 1 = address counts down |
| auto_init_i | input | 4 | Per channel: 1 = reload from base at end of process |
| width16_i | input | 4 | Per channel: 1 = 16-bit transfers |
| wide_mode_i | input | 1 | 16-bit transfer mode enabled |
| m2m_i | input | 1 | Memory-to-memory move in progress |
| phase_i | input | 2 | Controller state: 0 idle, 1 S1, 2 S2, 3 other active |
| ext_eop_i | input | 1 | External end-of-process request, active high |
| cur_addr_o | output | 16 | Current address of the active channel |
| cur_cnt_o | output | 16 | Current count of the active channel |
| mask_o | output | 4 | Per-channel mask bits |
| tc_o | output | 1 | Terminal-count pulse |
| eop_o | output | 1 | End-of-process pulse |
| dwle_o | output | 1 | Width indication / high-byte latch enable |
| dwle_oe_o | output | 1 | Output enable for `dwle_o` |

## Verification
The step logic is driven from a vector table that crosses both directions with both step sizes. Some vectors start at the extremes of the address range, and some have counts of zero and one. This separates a wrong sign, a wrong step size, a missing wrap and an off-by-one underflow test. The table also includes a channel whose width bit is set while wide mode is off, which shows whether the mode gate works. Directed sequences then compare reload against masking at end of process, and an external request raised in an idle phase against one raised in an active phase. A further case lets the held request lapse through idle. The last sequences step the memory-to-memory pair with only the partner channel set wide, which shows whether the pair rule, rather than the active channel's own bit, picks the width and the `dwle_o` level.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam int AW = 16;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_S1   = 2'd1,
    PH_S2   = 2'd2,
    PH_ACT  = 2'd3
  } phase_t;

  function automatic logic [AW-1:0] step_size(input logic wide);
    return wide ? AW'(2) : AW'(1);
  endfunction

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] addr,
                                              input logic dn, input logic wide);
    return dn ? (addr - step_size(wide)) : (addr + step_size(wide));
  endfunction

  function automatic logic [AW-1:0] next_cnt(input logic [AW-1:0] cnt,
                                             input logic wide);
    return cnt - step_size(wide);
  endfunction

  function automatic logic cnt_underflow(input logic [AW-1:0] cnt,
                                         input logic wide);
    return cnt < step_size(wide);
  endfunction
endpackage

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_eng_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [AW-1:0] ld_cnt_i,
  input  logic          step_i,
  input  logic          wide_i,
  input  logic          dn_i,
  input  logic          auto_i,
  input  logic          ext_end_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] cnt_o,
  output logic          mask_o,
  output logic          tc_o
);
  logic [AW-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
  logic          mask_q;
  logic          uf_hit, end_evt;

  assign uf_hit  = step_i && cnt_underflow(cur_cnt_q, wide_i);
  assign end_evt = uf_hit || ext_end_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      mask_q      <= 1'b1;
    end else if (ld_i) begin
      base_addr_q <= ld_addr_i;
      base_cnt_q  <= ld_cnt_i;
      cur_addr_q  <= ld_addr_i;
      cur_cnt_q   <= ld_cnt_i;
      mask_q      <= 1'b0;
    end else begin
      if (step_i) begin
        cur_addr_q <= next_addr(cur_addr_q, dn_i, wide_i);
        cur_cnt_q  <= next_cnt(cur_cnt_q, wide_i);
      end
      if (end_evt) begin
        if (auto_i) begin
          cur_addr_q <= base_addr_q;
          cur_cnt_q  <= base_cnt_q;
        end else begin
          mask_q <= 1'b1;
        end
      end
    end
  end

  assign addr_o = cur_addr_q;
  assign cnt_o  = cur_cnt_q;
  assign mask_o = mask_q;
  assign tc_o   = uf_hit;

  // R2
  load_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (!mask_q && cur_addr_q == base_addr_q && cur_cnt_q == base_cnt_q));

  // R3
  step_dist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !end_evt && !ld_i) |=>
      (($past(cur_cnt_q) - cur_cnt_q) ==
       ($past(dn_i) ? ($past(cur_addr_q) - cur_addr_q)
                    : (cur_addr_q - $past(cur_addr_q)))));

  // R7
  end_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && !auto_i && !ld_i) |=> mask_q);

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && auto_i && !ld_i) |=>
      (cur_addr_q == $past(base_addr_q) && cur_cnt_q == $past(base_cnt_q)
       && mask_q == $past(mask_q)));
endmodule

// File: rtl/dma_eop_gate.sv
module dma_eop_gate
  import dma_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] phase_i,
  input  logic       eop_req_i,
  output logic       act_o
);
  phase_t phase;
  logic   held_q;

  assign phase = phase_t'(phase_i);
  assign act_o = held_q && (phase == PH_S2);

  always_ff @(posedge clk) begin
    if (!rst_n)                held_q <= 1'b0;
    else if (phase == PH_IDLE) held_q <= 1'b0;
    else                       held_q <= (held_q && !act_o) || eop_req_i;
  end

  // R10
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |=> !held_q);

  // R9
  active_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_o |-> $past(phase != PH_IDLE));
endmodule

// File: rtl/dma_width_sel.sv
module dma_width_sel
  import dma_eng_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wide_i,
  input  logic           m2m_i,
  input  logic [CW-1:0]  act_ch_i,
  input  logic [NCH-1:0] w16_i,
  input  logic [1:0]     phase_i,
  output logic           eff16_o,
  output logic           dwle_o,
  output logic           dwle_oe_o
);
  logic in_pair, pair16;

  assign in_pair = m2m_i && (act_ch_i <= CW'(1));
  assign pair16  = w16_i[0] | w16_i[1];
  assign eff16_o = wide_i && (in_pair ? pair16 : w16_i[act_ch_i]);

  always_comb begin
    if (!wide_i)                          dwle_o = 1'b0;
    else if (phase_t'(phase_i) == PH_S1)  dwle_o = !eff16_o;
    else                                  dwle_o = m2m_i && eff16_o;
  end
  assign dwle_oe_o = wide_i;

  // R11
  pair_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_i && in_pair && !eff16_o) |-> (w16_i[1:0] == 2'b00));

  // R12
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dwle_oe_o |-> !dwle_o);
endmodule

// File: rtl/dma_addr_cnt_engine.sv
module dma_addr_cnt_engine
  import dma_eng_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_i,
  input  logic [CW-1:0]  ld_ch_i,
  input  logic [AW-1:0]  ld_addr_i,
  input  logic [AW-1:0]  ld_cnt_i,
  input  logic           xfer_done_i,
  input  logic [CW-1:0]  act_ch_i,
  input  logic [NCH-1:0] dir_dn_i,
  input  logic [NCH-1:0] auto_init_i,
  input  logic [NCH-1:0] width16_i,
  input  logic           wide_mode_i,
  input  logic           m2m_i,
  input  logic [1:0]     phase_i,
  input  logic           ext_eop_i,
  output logic [AW-1:0]  cur_addr_o,
  output logic [AW-1:0]  cur_cnt_o,
  output logic [NCH-1:0] mask_o,
  output logic           tc_o,
  output logic           eop_o,
  output logic           dwle_o,
  output logic           dwle_oe_o
);
  logic [AW-1:0]  addr_w [NCH];
  logic [AW-1:0]  cnt_w  [NCH];
  logic [NCH-1:0] tc_hit_w;
  logic           eff16_w, eop_act_w;
  logic           tc_q, eop_q;

  dma_eop_gate u_eop (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_i),
    .eop_req_i(ext_eop_i), .act_o(eop_act_w)
  );

  dma_width_sel #(.NCH(NCH)) u_width (
    .clk(clk), .rst_n(rst_n), .wide_i(wide_mode_i), .m2m_i(m2m_i),
    .act_ch_i(act_ch_i), .w16_i(width16_i), .phase_i(phase_i),
    .eff16_o(eff16_w), .dwle_o(dwle_o), .dwle_oe_o(dwle_oe_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic sel;
    assign sel = (act_ch_i == CW'(g));
    dma_chan_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .ld_i(ld_i && (ld_ch_i == CW'(g))),
      .ld_addr_i(ld_addr_i), .ld_cnt_i(ld_cnt_i),
      .step_i(xfer_done_i && sel),
      .wide_i(eff16_w),
      .dn_i(dir_dn_i[g]), .auto_i(auto_init_i[g]),
      .ext_end_i(eop_act_w && sel),
      .addr_o(addr_w[g]), .cnt_o(cnt_w[g]),
      .mask_o(mask_o[g]), .tc_o(tc_hit_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_q  <= 1'b0;
      eop_q <= 1'b0;
    end else begin
      tc_q  <= |tc_hit_w;
      eop_q <= (|tc_hit_w) || eop_act_w;
    end
  end

  assign cur_addr_o = addr_w[act_ch_i];
  assign cur_cnt_o  = cnt_w[act_ch_i];
  assign tc_o       = tc_q;
  assign eop_o      = eop_q;

  // R6
  tc_implies_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> eop_o);

  // R6
  single_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_hit_w));
endmodule

// File: tb/dma_addr_cnt_engine_test.sv
module dma_addr_cnt_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {ch[1:0], dn, w16, wide, exp_tc, 2'b00}, start addr, start cnt, exp addr, exp cnt
  localparam logic [71:0] VEC [NV] = '{
    {8'h00, 16'h1000, 16'h0005, 16'h1001, 16'h0004},
    {8'h60, 16'h2000, 16'h0003, 16'h1FFF, 16'h0002},
    {8'h98, 16'h3000, 16'h000A, 16'h3002, 16'h0008},
    {8'hF8, 16'h0000, 16'h0004, 16'hFFFE, 16'h0002},
    {8'h94, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF},
    {8'h5C, 16'hFFFE, 16'h0001, 16'h0000, 16'hFFFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld = 0, xfer = 0, wide = 0, m2m = 0, eop_req = 0;
  logic [1:0] ld_ch = 0, act_ch = 0, phase = 0;
  logic [15:0] ld_addr = 0, ld_cnt = 0;
  logic [3:0] dn = 0, autoi = 0, w16 = 0;
  logic [15:0] cur_addr, cur_cnt;
  logic [3:0] mask;
  logic tc, eop, dwle, dwle_oe;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_cnt_engine uut (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .ld_ch_i(ld_ch), .ld_addr_i(ld_addr),
    .ld_cnt_i(ld_cnt), .xfer_done_i(xfer), .act_ch_i(act_ch), .dir_dn_i(dn),
    .auto_init_i(autoi), .width16_i(w16), .wide_mode_i(wide), .m2m_i(m2m),
    .phase_i(phase), .ext_eop_i(eop_req), .cur_addr_o(cur_addr),
    .cur_cnt_o(cur_cnt), .mask_o(mask), .tc_o(tc), .eop_o(eop),
    .dwle_o(dwle), .dwle_oe_o(dwle_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [1:0] ch, input logic [15:0] a, input logic [15:0] c);
    ld = 1; ld_ch = ch; ld_addr = a; ld_cnt = c;
    tick();
    ld = 0;
  endtask

  task automatic pulse_xfer(input logic [1:0] ch);
    act_ch = ch; xfer = 1;
    tick();
    xfer = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 addr", 32'(cur_addr), 32'h0);
    chk("R1 cnt", 32'(cur_cnt), 32'h0);
    chk("R1 mask", 32'(mask), 32'hF);
    chk("R1 tc", 32'(tc), 32'h0);
    chk("R1 eop", 32'(eop), 32'h0);

    // R3 R4 R5 R6 table of single steps
    for (int i = 0; i < NV; i++) begin
      logic [7:0] f;
      logic [1:0] ch;
      f = VEC[i][71:64];
      ch = f[7:6];
      dn[ch] = f[5]; w16[ch] = f[4]; wide = f[3]; autoi = 4'h0;
      load(ch, VEC[i][63:48], VEC[i][47:32]);
      act_ch = ch;
      #1;
      chk("R2 load mask", 32'(mask[ch]), 32'h0);
      chk("R2 load addr", 32'(cur_addr), 32'(VEC[i][63:48]));
      pulse_xfer(ch);
      chk("R3 R4 R5 addr", 32'(cur_addr), 32'(VEC[i][31:16]));
      chk("R3 R4 R5 cnt", 32'(cur_cnt), 32'(VEC[i][15:0]));
      chk("R6 tc", 32'(tc), 32'(f[2]));
      chk("R6 eop", 32'(eop), 32'(f[2]));
    end
    w16 = 0; dn = 0; wide = 0;

    // R7 end without autoinit masks, keeps stepped values
    load(2'd3, 16'h0010, 16'h0000);
    pulse_xfer(2'd3);
    chk("R7 mask", 32'(mask[3]), 32'h1);
    chk("R7 addr", 32'(cur_addr), 32'h0011);
    chk("R7 cnt", 32'(cur_cnt), 32'hFFFF);

    // R8 autoinit reload
    autoi[0] = 1;
    load(2'd0, 16'h4000, 16'h0001);
    pulse_xfer(2'd0);
    chk("R8 first step", 32'(cur_addr), 32'h4001);
    chk("R6 no tc early", 32'(tc), 32'h0);
    pulse_xfer(2'd0);
    chk("R6 tc", 32'(tc), 32'h1);
    chk("R8 addr reload", 32'(cur_addr), 32'h4000);
    chk("R8 cnt reload", 32'(cur_cnt), 32'h0001);
    chk("R8 mask clear", 32'(mask[0]), 32'h0);
    tick();
    chk("R6 tc one cycle", 32'(tc), 32'h0);
    chk("R6 eop one cycle", 32'(eop), 32'h0);
    autoi = 0;

    // R9 external request ignored in idle, honoured when active
    load(2'd1, 16'h5000, 16'h0009);
    act_ch = 2'd1;
    phase = 2'd0; eop_req = 1; tick();
    eop_req = 0; phase = 2'd2; tick();
    chk("R9 idle ignored eop", 32'(eop), 32'h0);
    chk("R9 idle ignored mask", 32'(mask[1]), 32'h0);
    phase = 2'd3; eop_req = 1; tick();
    eop_req = 0; phase = 2'd2; tick();
    chk("R9 eop", 32'(eop), 32'h1);
    chk("R9 tc low", 32'(tc), 32'h0);
    chk("R9 mask", 32'(mask[1]), 32'h1);
    chk("R9 cnt kept", 32'(cur_cnt), 32'h0009);
    phase = 2'd3; tick();
    chk("R9 eop one cycle", 32'(eop), 32'h0);

    // R10 held request dropped through idle
    load(2'd1, 16'h5000, 16'h0009);
    phase = 2'd3; eop_req = 1; tick();
    eop_req = 0; phase = 2'd0; tick();
    phase = 2'd2; tick();
    chk("R10 eop", 32'(eop), 32'h0);
    chk("R10 mask", 32'(mask[1]), 32'h0);
    phase = 2'd0;

    // R11 R12 memory-to-memory pair
    wide = 1; m2m = 1; w16 = 4'b0010;
    load(2'd0, 16'h6000, 16'h0008);
    act_ch = 2'd0; phase = 2'd1;
    #1;
    chk("R12 oe", 32'(dwle_oe), 32'h1);
    chk("R12 S1 pair 16", 32'(dwle), 32'h0);
    pulse_xfer(2'd0);
    chk("R11 addr", 32'(cur_addr), 32'h6002);
    chk("R11 cnt", 32'(cur_cnt), 32'h0006);
    w16 = 4'b0000;
    #1;
    chk("R12 S1 pair 8", 32'(dwle), 32'h1);
    pulse_xfer(2'd0);
    chk("R11 8-bit pair addr", 32'(cur_addr), 32'h6003);
    w16 = 4'b0010; phase = 2'd3;
    #1;
    chk("R12 latch enable", 32'(dwle), 32'h1);
    m2m = 0; phase = 2'd1;
    #1;
    chk("R12 S1 own width", 32'(dwle), 32'h1);
    phase = 2'd3;
    #1;
    chk("R12 no m2m outside S1", 32'(dwle), 32'h0);
    wide = 0; phase = 2'd1;
    #1;
    chk("R12 oe off", 32'(dwle_oe), 32'h0);
    chk("R12 value off", 32'(dwle), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule